// File: doc/BRIEF.md
# Supply and Clock Integrity Monitor

This block watches two things that keep a small controller alive: a supply-warning comparator and the main oscillator. The comparator output arrives as a digital level and is resynchronised into a warning flag. The block raises a warning interrupt each time that flag changes, whether the supply is dropping or recovering. The main clock is sampled by the always-running backup (safe) clock. When the main clock stops producing edges, the system clock is moved to the safe clock through a glitch-free switch and a sticky clock-fail flag is set. The system clock moves back to the main clock by itself once the main clock is stable again.

Software sees a single 8-bit control and status register. Bit 7 and bit 3 always read 0. Bit 6 is the warning-interrupt enable. Bit 5 is the warning flag (read-only). Bit 4 is the supply-reset flag. Bit 2 is the clock-fail interrupt enable. Bit 1 is the clock-fail flag. Bit 0 is the watchdog-reset flag. The register port, the detector and the interrupt logic run on the safe clock. A halt input freezes the register and pauses the clock supervisor. An option input switches the clock supervisor off completely.

Top module: `supclk_monitor`

## Requirements
- R1: After reset the register reads 00h while the comparator is low, both interrupt lines are low and the clock-on-safe status is 0.
- R2: A write updates only bit 6 and bit 2. Writing 1 to bits 7, 5, 4, 3, 1 or 0 has no effect. Bits 7 and 3 always read 0.
- R3: Bit 5 follows the comparator input three safe-clock edges after the input changes. While bit 6 is 1, every change of bit 5 in either direction raises the warning interrupt. The interrupt stays raised until the acknowledge input is sampled high. If a new change and an acknowledge fall in the same cycle, the request stays raised.
- R4: If no rising main-clock edge is seen for LOSS_CYC (8) consecutive safe-clock cycles, the clock-on-safe status goes to 1 and bit 1 is set. The clock-fail interrupt is high while bit 1 and bit 2 are both 1.
- R5: While on the safe clock, RECOVER_EDGES (16) consecutive rising main-clock edges, each within the loss window, return the clock-on-safe status to 0.
- R6: A read pulse clears bit 1 only if the clock-on-safe status is 0. A read made while still on the safe clock leaves bit 1 at 1.
- R7: While the supervisor option input is 0, bit 1 reads 0, the clock-fail interrupt is 0 and the clock-on-safe status is 0, even with the main clock stopped.
- R8: While halt is 1, writes, acknowledges, flag updates and comparator changes are ignored and the register reads unchanged. When halt is released, a comparator change made during halt is seen and raises the warning interrupt.
- R9: A pulse on the supply-reset event input sets bit 4, and a pulse on the watchdog-reset event input sets bit 0. Each flag is cleared only by writing 0 to its bit.
- R10: The system clock output equals the main clock when on the main clock, and equals the safe clock when on the safe clock. The two clock paths are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_safe_i | input | 1 | Backup safe clock; clocks register, detector and interrupts |
| clk_main_i | input | 1 | Main oscillator clock, monitored |
| rst_ni | input | 1 | Asynchronous active-low reset |
| css_en_i | input | 1 | Option: 1 enables the clock supervisor |
| halt_i | input | 1 | 1 freezes the register and pauses supervision |
| comp_i | input | 1 | Supply-warning comparator level (1 = below threshold) |
| supply_rst_evt_i | input | 1 | Pulse: supply reset occurred |
| wdg_rst_evt_i | input | 1 | Pulse: watchdog reset occurred |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe (clear-on-read side effect) |
| rd_data_o | output | 8 | Register read value |
| irq_ack_i | input | 1 | Warning interrupt service entry |
| irq_warn_o | output | 1 | Warning-level change interrupt request |
| irq_clk_o | output | 1 | Clock-fail interrupt request |
| sys_clk_o | output | 1 | Glitch-free switched system clock |
| clk_on_safe_o | output | 1 | 1 while the system clock runs from the safe clock |

## Verification
A warning-flag change and an interrupt acknowledge can land on the same clock edge. The bench arranges this by pulsing the acknowledge exactly on the third edge after the comparator toggles. It then expects the request to remain high, and expects a later acknowledge to clear it. A clock-fail read can also coincide with the safe-clock state. A read made while the main clock is still missing must leave the flag set. The same read made after recovery must clear it on the next edge.

// File: rtl/supclk_pkg.sv
package supclk_pkg;
   localparam int REG_W    = 8;
   localparam int B_WIE    = 6;
   localparam int B_WFLAG  = 5;
   localparam int B_SRST   = 4;
   localparam int B_CIE    = 2;
   localparam int B_CFAIL  = 1;
   localparam int B_WRST   = 0;
endpackage

// File: rtl/supclk_sync.sv
module supclk_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("supclk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= {st[STAGES-2:0], d};
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/supclk_loss_det.sv
module supclk_loss_det #(
   parameter int LOSS_CYC      = 8,
   parameter int RECOVER_EDGES = 16,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic hold,
   input  logic main_clk,
   output logic use_safe,
   output logic fail_evt
);
   localparam int GW = $clog2(LOSS_CYC);
   localparam int RW = $clog2(RECOVER_EDGES);
   localparam logic [GW-1:0] GAP_LAST = GW'(LOSS_CYC - 1);
   localparam logic [RW-1:0] REC_LAST = RW'(RECOVER_EDGES - 1);

   if (LOSS_CYC < 4) begin : g_bad_loss
      $error("supclk_loss_det: LOSS_CYC must be at least 4");
   end
   if (RECOVER_EDGES < 2) begin : g_bad_rec
      $error("supclk_loss_det: RECOVER_EDGES must be at least 2");
   end

   logic          ms, m_last, rise, starved;
   logic [GW-1:0] gap;
   logic [RW-1:0] rec;

   supclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_msync (
      .clk(clk), .rst_n(rst_n), .d(main_clk), .q(ms)
   );

   assign rise    = ms & ~m_last;
   assign starved = !rise && (gap == GAP_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_last   <= 1'b0;
         gap      <= '0;
         rec      <= '0;
         use_safe <= 1'b0;
         fail_evt <= 1'b0;
      end else begin
         fail_evt <= 1'b0;
         if (!enable) begin
            m_last   <= ms;
            gap      <= '0;
            rec      <= '0;
            use_safe <= 1'b0;
         end else if (!hold) begin
            m_last <= ms;
            if (rise)                 gap <= '0;
            else if (gap != GAP_LAST) gap <= gap + 1'b1;
            if (!use_safe) begin
               if (starved) begin
                  use_safe <= 1'b1;
                  fail_evt <= 1'b1;
                  rec      <= '0;
               end
            end else if (starved) begin
               rec <= '0;
            end else if (rise) begin
               if (rec == REC_LAST) begin
                  use_safe <= 1'b0;
                  rec      <= '0;
               end else begin
                  rec <= rec + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/supclk_switch.sv
module supclk_switch (
   input  logic clk_main,
   input  logic clk_safe,
   input  logic rst_n,
   input  logic use_safe,
   output logic sys_clk
);
   logic force_q, clr_m;
   logic m_s1, en_m;
   logic s_s1, en_s;

   always_ff @(posedge clk_safe or negedge rst_n) begin
      if (!rst_n) force_q <= 1'b0;
      else        force_q <= use_safe;
   end

   assign clr_m = force_q | ~rst_n;

   always_ff @(negedge clk_main or posedge clr_m) begin
      if (clr_m) begin
         m_s1 <= 1'b0;
         en_m <= 1'b0;
      end else begin
         m_s1 <= ~en_s;
         en_m <= m_s1;
      end
   end

   always_ff @(negedge clk_safe or negedge rst_n) begin
      if (!rst_n) begin
         s_s1 <= 1'b0;
         en_s <= 1'b0;
      end else begin
         s_s1 <= use_safe & ~en_m;
         en_s <= s_s1;
      end
   end

   assign sys_clk = (clk_main & en_m) | (clk_safe & en_s);
endmodule

// File: rtl/supclk_regs.sv
module supclk_regs
   import supclk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic             css_en,
   input  logic             warn_sync,
   input  logic             fail_evt,
   input  logic             on_safe,
   input  logic             srst_evt,
   input  logic             wrst_evt,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             rd_en,
   input  logic             ack,
   output logic [REG_W-1:0] rd_data,
   output logic             irq_warn,
   output logic             irq_clk
);
   logic wie, cie, warn_q, srf, wrf, cff, wpend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wie    <= 1'b0;
         cie    <= 1'b0;
         warn_q <= 1'b0;
         srf    <= 1'b0;
         wrf    <= 1'b0;
         cff    <= 1'b0;
         wpend  <= 1'b0;
      end else if (!halt) begin
         warn_q <= warn_sync;
         if ((warn_sync != warn_q) && wie) wpend <= 1'b1;
         else if (ack)                     wpend <= 1'b0;
         if (wr_en) begin
            wie <= wr_data[B_WIE];
            cie <= wr_data[B_CIE];
         end
         if (srst_evt)                         srf <= 1'b1;
         else if (wr_en && !wr_data[B_SRST])   srf <= 1'b0;
         if (wrst_evt)                         wrf <= 1'b1;
         else if (wr_en && !wr_data[B_WRST])   wrf <= 1'b0;
         if (!css_en)                cff <= 1'b0;
         else if (fail_evt)          cff <= 1'b1;
         else if (rd_en && !on_safe) cff <= 1'b0;
      end
   end

   always_comb begin
      rd_data          = '0;
      rd_data[B_WIE]   = wie;
      rd_data[B_WFLAG] = warn_q;
      rd_data[B_SRST]  = srf;
      rd_data[B_CIE]   = cie;
      rd_data[B_CFAIL] = cff & css_en;
      rd_data[B_WRST]  = wrf;
   end

   assign irq_warn = wpend;
   assign irq_clk  = cff & cie & css_en;
endmodule

// File: rtl/supclk_monitor.sv
module supclk_monitor
   import supclk_pkg::*;
#(
   parameter int LOSS_CYC      = 8,
   parameter int RECOVER_EDGES = 16,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk_safe_i,
   input  logic             clk_main_i,
   input  logic             rst_ni,
   input  logic             css_en_i,
   input  logic             halt_i,
   input  logic             comp_i,
   input  logic             supply_rst_evt_i,
   input  logic             wdg_rst_evt_i,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             rd_en_i,
   output logic [REG_W-1:0] rd_data_o,
   input  logic             irq_ack_i,
   output logic             irq_warn_o,
   output logic             irq_clk_o,
   output logic             sys_clk_o,
   output logic             clk_on_safe_o
);
   logic warn_sync, use_safe, fail_evt;

   supclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wsync (
      .clk(clk_safe_i), .rst_n(rst_ni), .d(comp_i), .q(warn_sync)
   );

   supclk_loss_det #(
      .LOSS_CYC(LOSS_CYC), .RECOVER_EDGES(RECOVER_EDGES), .SYNC_STAGES(SYNC_STAGES)
   ) u_det (
      .clk(clk_safe_i), .rst_n(rst_ni), .enable(css_en_i), .hold(halt_i),
      .main_clk(clk_main_i), .use_safe(use_safe), .fail_evt(fail_evt)
   );

   supclk_switch u_sw (
      .clk_main(clk_main_i), .clk_safe(clk_safe_i), .rst_n(rst_ni),
      .use_safe(use_safe), .sys_clk(sys_clk_o)
   );

   supclk_regs u_reg (
      .clk(clk_safe_i), .rst_n(rst_ni), .halt(halt_i), .css_en(css_en_i),
      .warn_sync(warn_sync), .fail_evt(fail_evt), .on_safe(use_safe),
      .srst_evt(supply_rst_evt_i), .wrst_evt(wdg_rst_evt_i),
      .wr_en(wr_en_i), .wr_data(wr_data_i), .rd_en(rd_en_i), .ack(irq_ack_i),
      .rd_data(rd_data_o), .irq_warn(irq_warn_o), .irq_clk(irq_clk_o)
   );

   assign clk_on_safe_o = use_safe;
endmodule

// File: rtl/supclk_monitor_chk.sv
module supclk_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       css_en,
   input logic       halt,
   input logic       rd_en,
   input logic [7:0] rd_data,
   input logic       irq_warn,
   input logic       irq_clk,
   input logic       on_safe,
   input logic       en_m,
   input logic       en_s
);
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[7] && !rd_data[3]); // R2
   AST_WIRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_warn) |-> $past(rd_data[6]) && !$stable(rd_data[5])); // R3
   AST_CFAIL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(on_safe) && !halt) |=> (rd_data[1] || !css_en)); // R4
   AST_CFAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && on_safe && rd_data[1] && !halt) |=> (rd_data[1] || !css_en)); // R6
   AST_CSS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !css_en |-> (!rd_data[1] && !irq_clk)); // R7
   AST_CSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !css_en |=> !on_safe); // R7
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> ($stable(rd_data[6:4]) && $stable(rd_data[2]) && $stable(rd_data[0]))); // R8
   AST_MUX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_m && en_s)); // R10
endmodule

bind supclk_monitor supclk_monitor_chk u_chk (
   .clk(clk_safe_i), .rst_n(rst_ni), .css_en(css_en_i), .halt(halt_i),
   .rd_en(rd_en_i), .rd_data(rd_data_o), .irq_warn(irq_warn_o), .irq_clk(irq_clk_o),
   .on_safe(clk_on_safe_o), .en_m(u_sw.en_m), .en_s(u_sw.en_s)
);

// File: tb/supclk_monitor_tb.sv
module supclk_monitor_tb_top;
   logic       clk = 1'b0;
   logic       main_clk = 1'b0;
   logic       main_run = 1'b1;
   logic       rst_n = 1'b0;
   logic       css_en = 1'b1, halt = 1'b0, comp = 1'b0;
   logic       srst_evt = 1'b0, wrst_evt = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       irq_warn, irq_clk, sys_clk, on_safe;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   supclk_monitor dut_i (
      .clk_safe_i(clk), .clk_main_i(main_clk), .rst_ni(rst_n), .css_en_i(css_en),
      .halt_i(halt), .comp_i(comp), .supply_rst_evt_i(srst_evt), .wdg_rst_evt_i(wrst_evt),
      .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
      .irq_ack_i(ack), .irq_warn_o(irq_warn), .irq_clk_o(irq_clk),
      .sys_clk_o(sys_clk), .clk_on_safe_o(on_safe)
   );

   // main clock: toggles every 2 safe cycles, 1 ns after a falling safe edge
   initial begin
      forever begin
         repeat (2) @(negedge clk);
         #1;
         if (main_run) main_clk = ~main_clk;
      end
   end

   // write value -> expected readback (comparator low, no flags pending)
   localparam logic [15:0] VEC [6] = '{16'hFF44, 16'h0000, 16'h4040,
                                       16'h0404, 16'hBB00, 16'h5E44};

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_pulse();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ack_pulse();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   initial begin
      #1ms;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(10);
      // R1 reset state
      check("R1 reg", rd_data, 8'h00);
      check("R1 irqs", {6'd0, irq_warn, irq_clk}, 8'h00);
      check("R1 on_safe", {7'd0, on_safe}, 8'h00);

      // R2 table walk
      foreach (VEC[i]) begin
         wr(VEC[i][15:8]);
         check("R2 write mask", rd_data, VEC[i][7:0]);
      end

      // R10 system clock follows main clock
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         check("R10 main path", {7'd0, sys_clk}, {7'd0, main_clk});
         @(negedge clk);
      end

      // R3 warning flag and interrupt on both directions
      wr(8'h40);
      comp = 1'b1;
      tick(4);
      check("R3 flag rise", rd_data, 8'h60);
      check("R3 irq rise", {7'd0, irq_warn}, 8'h01);
      ack_pulse();
      check("R3 ack clears", {7'd0, irq_warn}, 8'h00);
      comp = 1'b0;
      tick(4);
      check("R3 irq fall", {7'd0, irq_warn}, 8'h01);
      check("R3 flag fall", rd_data, 8'h40);
      ack_pulse();
      // R3 toggle and ack on the same edge: request must stay
      comp = 1'b1;
      tick(2);
      ack = 1'b1;
      tick(1);
      ack = 1'b0;
      check("R3 set beats ack", {7'd0, irq_warn}, 8'h01);
      ack_pulse();
      check("R3 later ack", {7'd0, irq_warn}, 8'h00);
      // comparator change with enable off: no request
      wr(8'h00);
      comp = 1'b0;
      tick(4);
      check("R3 disabled", {7'd0, irq_warn}, 8'h00);

      // R9 reset-cause flags
      srst_evt = 1'b1; wrst_evt = 1'b1;
      tick(1);
      srst_evt = 1'b0; wrst_evt = 1'b0;
      check("R9 set", rd_data, 8'h11);
      wr(8'h10);
      check("R9 clear wdg only", rd_data, 8'h10);
      wr(8'h00);
      check("R9 clear supply", rd_data, 8'h00);

      // R8 halt freezes
      wr(8'h44);
      halt = 1'b1;
      tick(1);
      wr(8'h00);
      comp = 1'b1;
      tick(6);
      check("R8 frozen reg", rd_data, 8'h44);
      check("R8 no irq", {7'd0, irq_warn}, 8'h00);
      halt = 1'b0;
      tick(2);
      check("R8 resume flag", rd_data, 8'h64);
      check("R8 resume irq", {7'd0, irq_warn}, 8'h01);
      ack_pulse();

      // R4 loss of main clock
      main_run = 1'b0;
      tick(25);
      check("R4 on_safe", {7'd0, on_safe}, 8'h01);
      check("R4 flag", rd_data & 8'h02, 8'h02);
      check("R4 irq_clk", {7'd0, irq_clk}, 8'h01);
      @(posedge clk); #1;
      check("R10 safe path", {7'd0, sys_clk}, 8'h01);
      @(negedge clk);
      // R6 read while on safe clock keeps flag
      rd_pulse();
      tick(1);
      check("R6 keep on safe", rd_data & 8'h02, 8'h02);
      // R5 recovery
      main_run = 1'b1;
      tick(120);
      check("R5 back to main", {7'd0, on_safe}, 8'h00);
      check("R6 flag until read", rd_data & 8'h02, 8'h02);
      rd_pulse();
      check("R6 cleared by read", rd_data & 8'h02, 8'h00);
      check("R6 irq_clk low", {7'd0, irq_clk}, 8'h00);
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); #1;
         check("R10 main after recovery", {7'd0, sys_clk}, {7'd0, main_clk});
         @(negedge clk);
      end

      // R7 supervisor disabled
      main_run = 1'b0;
      tick(25);
      check("R7 precondition", {7'd0, on_safe}, 8'h01);
      css_en = 1'b0;
      tick(1);
      check("R7 flag masked", rd_data & 8'h02, 8'h00);
      check("R7 irq masked", {7'd0, irq_clk}, 8'h00);
      tick(25);
      check("R7 no switch", {7'd0, on_safe}, 8'h00);
      css_en = 1'b1;
      main_run = 1'b1;
      tick(10);

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule